// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets clocked logic read and write an external asynchronous static RAM that is 131072 bytes deep, organised as 17 address bits by 8 data bits. The memory has three active-low strobes: chip select, output enable and write enable. The user side issues a one-cycle request with a direction flag, an address and a write byte. When a read finishes, the block returns the byte together with a one-cycle completion pulse. A write gives the same pulse when it ends.

Every phase length is computed at elaboration time. The clock period and the memory's access limits are converted to whole clock counts by ceiling division, and one extra cycle is added as margin for skew between the register and the pin. A parameter selects between two speed grades: the 55 ns grade and the 70 ns grade. The controller drives the shared data lines only while write enable is low. After every read it waits out the memory's bus-release time before it accepts new work. The memory stays in standby, with chip select high, whenever the controller is idle.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, and whenever idle, the controller holds `mem_ce_n`, `mem_oe_n` and `mem_we_n` at 1 and `mem_dq_oe` at 0. In this state `ready` is 1 and `done` is 0.
- R2: A read (`req_we`=0) holds `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for exactly RD_CYC consecutive cycles. RD_CYC is ceil(tRC/CLK_PERIOD_NS)+1, where tRC is 55 ns for the fast grade and 70 ns for the slow grade. With the defaults (20 ns clock, fast grade) RD_CYC is 4.
- R3: Read data is sampled from `mem_dq_i` on the edge that ends the read strobe. `rdata` then holds that byte while `done` is 1 for exactly one cycle. `done` rises RD_CYC clock edges after the edge that accepted the request.
- R4: A write (`req_we`=1) holds `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1 for exactly WR_CYC cycles, with `mem_dq_o` equal to the write byte. WR_CYC is ceil(max(tWP, tAW, tDW)/CLK_PERIOD_NS)+1, where the limits are 40/50/25 ns for the fast grade and 50/60/30 ns for the slow grade. The default WR_CYC is 4. `done` pulses for one cycle as the write ends.
- R5: `mem_dq_oe` is 1 only while `mem_we_n` is 0.
- R6: After each read, the controller keeps all strobes high and `ready` at 0 for TRN_CYC cycles after the `done` pulse. TRN_CYC is ceil(tOHZ/CLK_PERIOD_NS)+1, where tOHZ is 20 ns for the fast grade and 25 ns for the slow grade. The default TRN_CYC is 2.
- R7: A request presented while `ready` is 0 is ignored. It produces no `done` pulse and changes no memory location.
- R8: All 17 address bits reach `mem_addr` unchanged throughout an access, including addresses 0 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request strobe, taken when ready is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller can take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data lines |
| mem_dq_i | input | 8 | Data arriving from the memory |

## Verification
Several rules are checked on every cycle by the embedded assertions. The data lines are never driven without write enable low. A read strobe never overlaps write enable. Chip select is high in idle. The completion pulse lasts one cycle. Each write strobe is at least WR_CYC cycles wide. No write starts before the bus-release wait has elapsed. Other behaviour can only be shown by the bench's scenarios against a behavioural memory: exact strobe lengths, the read latency, data integrity at the extreme addresses, and a request being dropped while busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } ctrl_state_e;

    // ceiling division of a time limit by the clock period
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] rdata;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = finish;
        if (capture) c_d.rdata = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign done  = c_q.done;
    assign rdata = c_q.rdata;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done); // R3

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter bit          FAST_GRADE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // memory limits per speed grade, in ns
    localparam int unsigned T_RC  = FAST_GRADE ? 55 : 70;
    localparam int unsigned T_WP  = FAST_GRADE ? 40 : 50;
    localparam int unsigned T_AW  = FAST_GRADE ? 50 : 60;
    localparam int unsigned T_DW  = FAST_GRADE ? 25 : 30;
    localparam int unsigned T_OHZ = FAST_GRADE ? 20 : 25;

    // cycle counts, each with one margin cycle
    localparam int unsigned RD_CYC  = ns_to_cyc(T_RC, CLK_PERIOD_NS) + 1;
    localparam int unsigned WR_CYC  = ns_to_cyc(max3(T_WP, T_AW, T_DW), CLK_PERIOD_NS) + 1;
    localparam int unsigned TRN_CYC = ns_to_cyc(T_OHZ, CLK_PERIOD_NS) + 1;
    localparam int unsigned MAX_CYC = max3(RD_CYC, WR_CYC, TRN_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TRN_LOAD = CNT_W'(TRN_CYC - 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             finish;
    logic             capture;

    sram_phase_cnt #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .at_zero  (cnt_zero)
    );

    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        finish   = 1'b0;
        capture  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.ce_n  = 1'b0;
                    cnt_load  = 1'b1;
                    if (req_we) begin
                        r_d.state = ST_WRITE;
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        cnt_val   = WR_LOAD;
                    end else begin
                        r_d.state = ST_READ;
                        r_d.oe_n  = 1'b0;
                        cnt_val   = RD_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    capture   = 1'b1;
                    finish    = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.state = ST_TURN;
                    cnt_load  = 1'b1;
                    cnt_val   = TRN_LOAD;
                end
            end
            ST_WRITE: begin
                if (cnt_zero) begin
                    finish    = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.state = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (cnt_zero) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .finish  (finish),
        .capture (capture),
        .din     (mem_dq_i),
        .done    (done),
        .rdata   (rdata)
    );

    assign ready     = (r_q.state == ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;

    // ---- timing watchers for the assertions ----
    logic [CNT_W:0] rel_cnt_q;   // cycles since output enable went high
    logic [CNT_W:0] wlow_cnt_q;  // cycles write enable has been low

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_cnt_q  <= (CNT_W+1)'(TRN_CYC);
            wlow_cnt_q <= '0;
        end else begin
            if (!r_q.oe_n)                          rel_cnt_q <= '0;
            else if (rel_cnt_q < (CNT_W+1)'(TRN_CYC)) rel_cnt_q <= rel_cnt_q + 1'b1;
            if (r_q.we_n)                           wlow_cnt_q <= '0;
            else if (wlow_cnt_q < (CNT_W+1)'(MAX_CYC)) wlow_cnt_q <= wlow_cnt_q + 1'b1;
        end
    end

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1
    AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R2
    AST_WR_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wlow_cnt_q >= (CNT_W+1)'(WR_CYC))); // R4
    AST_DRIVE_ONLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n); // R5
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (rel_cnt_q >= (CNT_W+1)'(TRN_CYC))); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8

endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

    localparam int unsigned PERIOD  = 20;
    // expected counts derived from the requirements for the default grade
    localparam int unsigned RD_CYC  = (55 + PERIOD - 1) / PERIOD + 1;
    localparam int unsigned WR_CYC  = (50 + PERIOD - 1) / PERIOD + 1;
    localparam int unsigned TRN_CYC = (20 + PERIOD - 1) / PERIOD + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, done;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = '0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit       is_read;
        bit [7:0] data;
    } exp_t;
    exp_t sb_q[$];

    bit [7:0] mem_model [int];

    always #(PERIOD/2) clk = ~clk;

    sram_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .done(done), .rdata(rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    // behavioural memory, updated away from the active edge
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe)
            mem_model[int'(mem_addr)] = mem_dq_o;
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_i = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'h00;
        else
            mem_dq_i = 8'h00;
    end

    // monitor: scoreboard, strobe widths, bus drive rule
    int oe_low = 0;
    int we_low = 0;
    int drive_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.is_read) check(rdata == e.data, "R3 read data", rdata, e.data);
                end
            end
            if (!mem_oe_n) oe_low++;
            else if (oe_low != 0) begin
                check(oe_low == RD_CYC, "R2 read strobe length", oe_low, RD_CYC);
                oe_low = 0;
            end
            if (!mem_we_n) begin
                we_low++;
                check(mem_oe_n && !mem_ce_n, "R4 write strobes", {mem_ce_n, mem_oe_n}, 2'b01);
            end else if (we_low != 0) begin
                check(we_low == WR_CYC, "R4 write strobe length", we_low, WR_CYC);
                we_low = 0;
            end
            if (mem_dq_oe && mem_we_n) drive_bad++;
        end
    end

    task automatic do_op(input bit we, input logic [16:0] a, input logic [7:0] d,
                         input logic [7:0] exp_rd);
        exp_t e;
        int lat;
        while (!ready) @(negedge clk);
        e.is_read = !we;
        e.data    = exp_rd;
        sb_q.push_back(e);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        check(mem_addr == a, "R8 address on pins", mem_addr, a);
        if (we) check(mem_dq_o == d && mem_dq_oe, "R4 write data driven", mem_dq_o, d);
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        // done is seen at the negedge after the (N)th edge following acceptance
        if (we) check(lat == WR_CYC + 1, "R4 write latency", lat, WR_CYC + 1);
        else    check(lat == RD_CYC + 1, "R3 read latency", lat, RD_CYC + 1);
        @(negedge clk);
        check(!done, "R3 done single cycle", done, 0);
        if (!we) begin
            int trn;
            trn = 1;
            while (!ready && trn < 20) begin
                check(mem_ce_n && mem_oe_n && mem_we_n, "R6 strobes high in turnaround",
                      {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
                @(negedge clk);
                trn++;
            end
            check(trn == TRN_CYC, "R6 turnaround length", trn, TRN_CYC);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done,
              "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready, "R1 ready after reset", ready, 1);

        do_op(1'b1, 17'h00000, 8'hA5, 8'h00);
        do_op(1'b1, 17'h1FFFF, 8'h3C, 8'h00);
        do_op(1'b1, 17'h0AAAA, 8'h5A, 8'h00);
        do_op(1'b0, 17'h00000, 8'h00, 8'hA5);
        do_op(1'b0, 17'h1FFFF, 8'h00, 8'h3C);
        do_op(1'b0, 17'h0AAAA, 8'h00, 8'h5A);
        // read followed directly by write and another read
        do_op(1'b0, 17'h1FFFF, 8'h00, 8'h3C);
        do_op(1'b1, 17'h15555, 8'hFF, 8'h00);
        do_op(1'b0, 17'h15555, 8'h00, 8'hFF);
        check(ready && mem_ce_n, "R1 idle standby", {ready, mem_ce_n}, 2'b11);

        // R7: request while busy is dropped
        begin
            exp_t e;
            while (!ready) @(negedge clk);
            e.is_read = 1'b1; e.data = 8'hA5;
            sb_q.push_back(e);
            req = 1'b1; req_we = 1'b0; req_addr = 17'h00000;
            @(negedge clk);
            req = 1'b0;
            @(negedge clk);
            check(!ready, "R7 busy during read", ready, 0);
            req = 1'b1; req_we = 1'b1; req_addr = 17'h0AAAA; req_wdata = 8'h11;
            @(negedge clk);
            req = 1'b0;
            while (!done) @(negedge clk);
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R7 no extra completion", sb_q.size(), 0);
        do_op(1'b0, 17'h0AAAA, 8'h00, 8'h5A); // R7: location unchanged

        check(drive_bad == 0, "R5 drive without write enable", drive_bad, 0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule